// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit multiplication and division, signed or unsigned, one bit per clock, and keeps the outcome in two result registers named HI and LO. A pulse on `start` carries a function code and two source operands. A legal code moves the block out of idle. It then spends one cycle preparing the operands and 32 cycles iterating. The registers are written on the final iteration edge, and `done` is raised for one cycle.

The multiply and divide paths share one set of iteration registers. Multiplication uses shift-and-add and places the 64-bit product across HI:LO, with the upper half in HI. Division uses a restoring algorithm and places the quotient in LO and the remainder in HI. Signed operations iterate on magnitudes and fix the signs afterwards. A read port returns HI or LO when it is given the move-from code for that register. Until a new result is written, both registers keep their old values.

The control state machine has three states. `ST_IDLE` moves to `ST_SETUP` when an accepted start arrives. `ST_SETUP` always moves to `ST_ITER`. `ST_ITER` stays in place for 32 steps and returns to `ST_IDLE` on the last step, which is also the edge that writes the results.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO hold zero, and `busy` and `done` are low.
- R2: A start is accepted only in idle, and only with function codes 0x18 (signed multiply), 0x19 (unsigned multiply), 0x1A (signed divide) or 0x1B (unsigned divide). A start with any other code leaves `busy` low and leaves HI and LO unchanged.
- R3: `busy` rises on the edge that accepts a start and stays high for exactly 33 cycles. `done` is high for exactly the one cycle after `busy` falls, and is never high together with `busy`.
- R4: Code 0x18 writes the two's-complement product of the operands, upper 32 bits to HI and lower 32 bits to LO.
- R5: Code 0x19 writes the unsigned 64-bit product, upper half to HI and lower half to LO.
- R6: Code 0x1A writes the signed quotient, truncated toward zero, to LO. It writes the remainder, which carries the sign of the dividend, to HI. 0x80000000 divided by -1 gives LO = 0x80000000 and HI = 0.
- R7: Code 0x1B writes the unsigned quotient to LO and the unsigned remainder to HI.
- R8: A divide by zero, signed or unsigned, completes in the normal time with LO = 0xFFFFFFFF and HI equal to the dividend.
- R9: A start pulse while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R10: The read port returns HI for select 0x10, LO for select 0x12, and zero for any other select. While an operation runs, it returns the values from before that operation.
- R11: HI and LO change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op_code | input | 6 | Function code of the requested operation |
| src_a | input | 32 | First operand (multiplicand or dividend) |
| src_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | High while an operation is being prepared or iterated |
| done | output | 1 | One-cycle pulse when results are written |
| rd_sel | input | 6 | Move-from code selecting HI (0x10) or LO (0x12) |
| rd_data | output | 32 | Selected result register, or zero |

## Verification
The assertions assume that `start` is driven to a known level in every cycle after reset, and that it may be high during `busy`. They do not assume it is held low. The bench exercises exactly that: it pulses start in the middle of an operation and checks that the pulse changes nothing. The assertions also assume that HI and LO are written only by a completed operation. For that reason, the bench sends illegal codes only while the block is idle and compares the read port before and after. All other inputs change only at the falling edge, so each operand is stable at the accepting edge.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER
    } md_state_t;

    // Low two bits of the function code select the operation.
    typedef enum logic [1:0] {
        OP_MULT  = 2'b00,
        OP_MULTU = 2'b01,
        OP_DIV   = 2'b10,
        OP_DIVU  = 2'b11
    } md_op_t;

    localparam logic [3:0] FN_GROUP = 4'b0110;  // codes 0x18..0x1B
    localparam logic [5:0] FN_MFHI  = 6'h10;
    localparam logic [5:0] FN_MFLO  = 6'h12;

endpackage

// File: rtl/muldiv_fsm.sv
module muldiv_fsm
    import muldiv_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic setup_en,
    output logic step_en,
    output logic finish,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    md_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_ITER;
            ST_ITER:  if (cnt_q == LAST) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (state_q == ST_SETUP)     cnt_q <= '0;
            else if (state_q == ST_ITER) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        accept   = 1'b0;
        setup_en = 1'b0;
        step_en  = 1'b0;
        finish   = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = req;
            ST_SETUP: begin
                setup_en = 1'b1;
                busy     = 1'b1;
            end
            ST_ITER: begin
                step_en = 1'b1;
                busy    = 1'b1;
                finish  = (cnt_q == LAST);
            end
            default: ;
        endcase
        done = done_q;
    end

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             is_div,
    input  logic             step,
    input  logic [WIDTH-1:0] mag_a,
    input  logic [WIDTH-1:0] mag_b,
    output logic [WIDTH-1:0] nxt_hi,
    output logic [WIDTH-1:0] nxt_lo
);
    // acc: running product-high / partial remainder; qr: multiplier / quotient
    logic [WIDTH:0]   acc_q, acc_d;
    logic [WIDTH-1:0] qr_q, qr_d;
    logic [WIDTH-1:0] m_q;
    logic             div_q;

    logic [WIDTH:0]   sum;
    logic [WIDTH:0]   shifted;
    logic [WIDTH+1:0] diff;

    always_comb begin
        sum     = {1'b0, acc_q[WIDTH-1:0]} + (qr_q[0] ? {1'b0, m_q} : '0);
        shifted = {acc_q[WIDTH-1:0], qr_q[WIDTH-1]};
        diff    = {1'b0, shifted} - {2'b00, m_q};
        if (div_q) begin
            if (!diff[WIDTH+1]) begin
                acc_d = diff[WIDTH:0];
                qr_d  = {qr_q[WIDTH-2:0], 1'b1};
            end else begin
                acc_d = shifted;
                qr_d  = {qr_q[WIDTH-2:0], 1'b0};
            end
        end else begin
            acc_d = {1'b0, sum[WIDTH:1]};
            qr_d  = {sum[0], qr_q[WIDTH-1:1]};
        end
        nxt_hi = acc_d[WIDTH-1:0];
        nxt_lo = qr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            qr_q  <= '0;
            m_q   <= '0;
            div_q <= 1'b0;
        end else if (load) begin
            acc_q <= '0;
            qr_q  <= is_div ? mag_a : mag_b;
            m_q   <= is_div ? mag_b : mag_a;
            div_q <= is_div;
        end else if (step) begin
            acc_q <= acc_d;
            qr_q  <= qr_d;
        end
    end

endmodule

// File: rtl/muldiv_sign.sv
module muldiv_sign
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  md_op_t           op,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] raw_hi,
    input  logic [WIDTH-1:0] raw_lo,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic [WIDTH-1:0] fix_hi,
    output logic [WIDTH-1:0] fix_lo
);
    logic is_signed, is_div, neg_a, neg_b, b_zero;
    logic [2*WIDTH-1:0] prod;

    always_comb begin
        is_signed = (op == OP_MULT) || (op == OP_DIV);
        is_div    = (op == OP_DIV) || (op == OP_DIVU);
        neg_a     = is_signed && opnd_a[WIDTH-1];
        neg_b     = is_signed && opnd_b[WIDTH-1];
        b_zero    = (opnd_b == '0);
        mag_a     = neg_a ? (~opnd_a + 1'b1) : opnd_a;
        mag_b     = neg_b ? (~opnd_b + 1'b1) : opnd_b;
        prod      = {raw_hi, raw_lo};
        if (neg_a ^ neg_b) prod = ~prod + 1'b1;
        if (is_div) begin
            fix_lo = ((neg_a ^ neg_b) && !b_zero) ? (~raw_lo + 1'b1) : raw_lo;
            fix_hi = neg_a ? (~raw_hi + 1'b1) : raw_hi;
        end else begin
            fix_hi = prod[2*WIDTH-1:WIDTH];
            fix_lo = prod[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       op_code,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic             busy,
    output logic             done,
    input  logic [5:0]       rd_sel,
    output logic [WIDTH-1:0] rd_data
);
    logic legal, accept, setup_en, step_en, finish;
    md_op_t op_q;
    logic [WIDTH-1:0] a_q, b_q, hi_q, lo_q;
    logic [WIDTH-1:0] mag_a, mag_b, raw_hi, raw_lo, fix_hi, fix_lo;
    logic is_div;

    assign legal  = start && (op_code[5:2] == FN_GROUP);
    assign is_div = (op_q == OP_DIV) || (op_q == OP_DIVU);

    muldiv_fsm #(.STEPS(WIDTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(legal), .accept(accept),
        .setup_en(setup_en), .step_en(step_en), .finish(finish),
        .busy(busy), .done(done)
    );

    muldiv_sign #(.WIDTH(WIDTH)) u_sign (
        .op(op_q), .opnd_a(a_q), .opnd_b(b_q), .raw_hi(raw_hi), .raw_lo(raw_lo),
        .mag_a(mag_a), .mag_b(mag_b), .fix_hi(fix_hi), .fix_lo(fix_lo)
    );

    muldiv_iter #(.WIDTH(WIDTH)) u_iter (
        .clk(clk), .rst_n(rst_n), .load(setup_en), .is_div(is_div),
        .step(step_en), .mag_a(mag_a), .mag_b(mag_b),
        .nxt_hi(raw_hi), .nxt_lo(raw_lo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_MULT;
            a_q  <= '0;
            b_q  <= '0;
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (accept) begin
                op_q <= md_op_t'(op_code[1:0]);
                a_q  <= src_a;
                b_q  <= src_b;
            end
            if (finish) begin
                hi_q <= fix_hi;
                lo_q <= fix_lo;
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            FN_MFHI: rd_data = hi_q;
            FN_MFLO: rd_data = lo_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi_q,
    input logic [WIDTH-1:0] lo_q
);
    localparam int RUNW = $clog2(WIDTH + 4) + 1;
    logic [RUNW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= '0;
        else        run_len <= busy ? run_len + 1'b1 : '0;
    end

    // R3: done lasts one cycle
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done and busy are exclusive
    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R3: busy window length measured by a counter
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RUNW'(WIDTH + 1)));

    // R2 / R9: busy only begins after a start request
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11: result registers move only with done
    assert_hilo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_unit muldiv_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  op_code = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        busy, done;
    logic [5:0]  rd_sel = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] prev_hi = '0, prev_lo = '0;

    always #10 clk = ~clk;

    muldiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .busy(busy), .done(done),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_hilo(output logic [31:0] hi, output logic [31:0] lo);
        rd_sel = 6'h10; #1; hi = rd_data;
        rd_sel = 6'h12; #1; lo = rd_data;
        rd_sel = 6'h00;
    endtask

    function automatic void model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] hi, output logic [31:0] lo);
        logic [63:0] p;
        case (fn)
            6'h18: begin p = 64'($signed(a)) * 64'($signed(b)); hi = p[63:32]; lo = p[31:0]; end
            6'h19: begin p = {32'h0, a} * {32'h0, b}; hi = p[63:32]; lo = p[31:0]; end
            6'h1A: begin
                if (b == 0) begin lo = '1; hi = a; end
                else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin lo = a; hi = 0; end
                else begin lo = $signed(a) / $signed(b); hi = $signed(a) % $signed(b); end
            end
            default: begin
                if (b == 0) begin lo = '1; hi = a; end
                else begin lo = a / b; hi = a % b; end
            end
        endcase
    endfunction

    // Runs one operation; optionally injects a second start mid-run (R9)
    // and checks the read port during busy (R10).
    task automatic run_op(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                          input string req, input bit inject);
        logic [31:0] eh, el, ah, al, bh, bl;
        int n = 0;
        model(fn, a, b, eh, el);
        @(negedge clk);
        op_code = fn; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; src_a = ~a; src_b = 32'h3;
        while (busy && n < 100) begin
            n++;
            if (n == 5) begin
                read_hilo(bh, bl);
                check(bh == prev_hi && bl == prev_lo, "R10 read during busy", {bh, bl}, {prev_hi, prev_lo});
                if (inject) begin op_code = 6'h1B; start = 1'b1; end
            end
            if (n == 6) start = 1'b0;
            @(negedge clk);
        end
        check(n == 33, {req, " R3 busy length"}, 64'(n), 64'd33);
        check(done == 1'b1, {req, " R3 done after busy"}, 64'(done), 64'd1);
        read_hilo(ah, al);
        check(ah == eh && al == el, req, {ah, al}, {eh, el});
        prev_hi = ah; prev_lo = al;
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R3 done single cycle", {62'd0, done, busy}, 64'd0);
    endtask

    task automatic test_reset();
        logic [31:0] h, l;
        read_hilo(h, l);
        check(h == 0 && l == 0, "R1 reset HI/LO", {h, l}, 64'd0);
        check(!busy && !done, "R1 reset busy/done", {62'd0, busy, done}, 64'd0);
    endtask

    task automatic test_illegal();
        logic [31:0] h, l;
        @(negedge clk);
        op_code = 6'h20; src_a = 32'h55; src_b = 32'h7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R2 illegal code ignored", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        read_hilo(h, l);
        check(h == prev_hi && l == prev_lo, "R2 HI/LO unchanged", {h, l}, {prev_hi, prev_lo});
    endtask

    task automatic test_rd_other();
        rd_sel = 6'h11; #1;
        check(rd_data == 0, "R10 other select gives zero", 64'(rd_data), 64'd0);
        rd_sel = 6'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_op(6'h18, 32'hFFFF_FFF9, 32'h0000_0006, "R4 signed multiply neg*pos", 1'b0);
        run_op(6'h18, 32'h8000_0000, 32'h8000_0000, "R4 signed multiply min*min", 1'b0);
        run_op(6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 unsigned multiply max", 1'b0);
        run_op(6'h19, 32'h1234_5678, 32'h9ABC_DEF0, "R5 unsigned multiply", 1'b1);
        run_op(6'h1A, 32'hFFFF_FFF9, 32'h0000_0002, "R6 signed divide -7/2", 1'b0);
        run_op(6'h1A, 32'h0000_0007, 32'hFFFF_FFFE, "R6 signed divide 7/-2", 1'b0);
        run_op(6'h1A, 32'h8000_0000, 32'hFFFF_FFFF, "R6 signed divide min/-1", 1'b0);
        run_op(6'h1B, 32'hFFFF_FFF0, 32'h0000_0007, "R7 unsigned divide", 1'b1);
        run_op(6'h1B, 32'h0000_0003, 32'h0000_0009, "R7 unsigned divide small", 1'b0);
        run_op(6'h1B, 32'hDEAD_BEEF, 32'h0000_0000, "R8 unsigned divide by zero", 1'b0);
        run_op(6'h1A, 32'hFFFF_FF00, 32'h0000_0000, "R8 signed divide by zero", 1'b0);
        run_op(6'h18, 32'h0000_1000, 32'h0000_0010, "R9 start during busy ignored", 1'b1);
        test_illegal();
        test_rd_other();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule